// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Burst SRAM

This block is a cycle-accurate model of a synchronous pipelined static RAM. It can be synthesized. Its shared data bus never needs idle cycles when the traffic switches between reads and writes. Each rising clock edge samples the following inputs:

- three chip selects
- a load/continue control
- a write strobe
- one write strobe per byte lane
- a clock enable

The word array is small, and its size is set by parameters. Address and control move through a two-stage pipeline. As a result, read data and write data occupy the bus in the same slot: the interval between the first and the second enabled rising edge after the address was taken.

A cycle with the load/continue control low starts a new operation. That operation is a deselect, a read or a write. A cycle with the control high continues the burst already in progress with the same operation type. A 2-bit offset counter supplies the low address bits of the continue cycles. The output enable and the sleep input act without the clock and can only float the bus. The clock enable freezes every register. A stalled cycle therefore keeps the bus exactly as it was.

Top module: `nt_burst_sram`

## Requirements
- R1: A cycle with `adv_ld`=0 and any of `ce1_n`=1, `ce2`=0 or `ce3_n`=1 starts no access, and the bus slot belonging to it stays high-impedance.
- R2: A selected load cycle (`ce1_n`=0, `ce2`=1, `ce3_n`=0, `adv_ld`=0) with `we_n`=1 reads the word at `addr`. The word is driven on `dq` after the first enabled rising edge that follows, and it stays driven until the second one.
- R3: A selected load cycle with `we_n`=0 writes the word at `addr`. `dq` is captured at the second enabled rising edge. Lane i is bits [9i+8:9i] and is stored only if `bw_n[i]`=0. The other lanes keep their old contents.
- R4: A write cycle in which every `bw_n` bit is 1 stores nothing, and its bus slot stays high-impedance.
- R5: With `adv_ld`=1, the burst continues with the same operation type. The address is the starting address with its low two bits replaced by (start low bits + n) mod 4, where n counts the continue cycles since the load. n advances on every continue cycle, including aborted writes and reads with `oe_n`=1.
- R6: Continue cycles that follow a deselect load start no access, and the bus stays high-impedance.
- R7: With `cke_n`=1 the rising edge is ignored and all state is held. A bus being driven with read data stays driven. A pending write waits for the next enabled edge.
- R8: `sleep`=1 floats `dq` at once, whatever the other inputs are.
- R9: `oe_n`=1 floats `dq` at once. The block never drives `dq` during a write slot, even with `oe_n`=0.
- R10: After reset, `dq` is high-impedance and the burst state is deselected.
- R11: Reads and writes may alternate on consecutive cycles with no idle slot. A read issued in the cycle after a write to the same word returns the newly written lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce1_n | input | 1 | Chip select, active low |
| ce2 | input | 1 | Chip select, active high |
| ce3_n | input | 1 | Chip select, active low |
| adv_ld | input | 1 | 0 loads a new operation, 1 continues the burst |
| we_n | input | 1 | 0 selects write on a load cycle |
| bw_n | input | LANES | Per-lane write strobes, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| cke_n | input | 1 | Clock enable, active low |
| sleep | input | 1 | Asynchronous bus float |
| addr | input | ADDR_W | Word address |
| dq | inout | LANES*LANE_W | Shared data bus |

## Verification
A read or write issued at enabled edge k owns the bus from shortly after edge k+1 until edge k+2, so a write's data is captured at k+2. A stalled edge shifts both times later by one cycle. The bench keeps a two-entry queue of issued operations that advances only on enabled edges, together with a reference word array that is updated when each write is issued. Half a cycle after each edge it compares `dq` with the value expected for the current slot. Because `oe_n` and `sleep` act without the clock, their effect is checked in the same slot in which they change.

// File: rtl/nt_burst_sram.sv
module nt_burst_sram #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ce1_n,
  input  logic                      ce2,
  input  logic                      ce3_n,
  input  logic                      adv_ld,
  input  logic                      we_n,
  input  logic [LANES-1:0]          bw_n,
  input  logic                      oe_n,
  input  logic                      cke_n,
  input  logic                      sleep,
  input  logic [ADDR_W-1:0]         addr,
  inout  wire  [LANES*LANE_W-1:0]   dq
);
  localparam int DW    = LANES * LANE_W;
  localparam int DEPTH = 1 << ADDR_W;

  typedef enum logic [1:0] {K_NONE = 2'd0, K_RD = 2'd1, K_WR = 2'd2} kind_t;

  kind_t             b_kind, cur_kind;
  logic [ADDR_W-1:0] b_base, base_a, cur_addr;
  logic [1:0]        cnt, nxt_cnt;
  logic              sel, go_rd, go_wr;

  logic              s1_rd, s1_wr, s2_wr, rd_v;
  logic [ADDR_W-1:0] s1_addr, s2_addr;
  logic [LANES-1:0]  s1_bw, s2_bw;
  logic [DW-1:0]     q, mem_word, fwd_word;
  logic [DW-1:0]     mem [DEPTH];

  assign sel      = !ce1_n && ce2 && !ce3_n;
  assign cur_kind = adv_ld ? b_kind : (sel ? (we_n ? K_RD : K_WR) : K_NONE);
  assign nxt_cnt  = adv_ld ? cnt + 2'd1 : 2'd0;
  assign base_a   = adv_ld ? b_base : addr;
  assign cur_addr = {base_a[ADDR_W-1:2], base_a[1:0] + nxt_cnt};
  assign go_rd    = (cur_kind == K_RD);
  assign go_wr    = (cur_kind == K_WR) && !(&bw_n);

  assign mem_word = mem[s1_addr];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign fwd_word[i*LANE_W +: LANE_W] =
      (s2_wr && !s2_bw[i] && (s2_addr == s1_addr)) ? dq[i*LANE_W +: LANE_W]
                                                   : mem_word[i*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_kind  <= K_NONE;
      b_base  <= '0;
      cnt     <= '0;
      s1_rd   <= 1'b0;
      s1_wr   <= 1'b0;
      s1_addr <= '0;
      s1_bw   <= '1;
      s2_wr   <= 1'b0;
      s2_addr <= '0;
      s2_bw   <= '1;
      rd_v    <= 1'b0;
      q       <= '0;
    end else if (!cke_n) begin
      if (!adv_ld) begin
        b_kind <= cur_kind;
        b_base <= addr;
      end
      cnt     <= nxt_cnt;
      s1_rd   <= go_rd;
      s1_wr   <= go_wr;
      s1_addr <= cur_addr;
      s1_bw   <= bw_n;
      s2_wr   <= s1_wr;
      s2_addr <= s1_addr;
      s2_bw   <= s1_bw;
      rd_v    <= s1_rd;
      if (s1_rd) q <= fwd_word;
    end
  end

  always_ff @(posedge clk) begin
    if (!cke_n && s2_wr) begin
      for (int i = 0; i < LANES; i++)
        if (!s2_bw[i]) mem[s2_addr][i*LANE_W +: LANE_W] <= dq[i*LANE_W +: LANE_W];
    end
  end

  assign dq = (rd_v && !oe_n && !sleep) ? q : {DW{1'bz}};

  assert_desel_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !adv_ld && !sel) |=> (!s1_rd && !s1_wr));

  assert_rd_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && s1_rd) |=> rd_v);

  assert_cnt_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && adv_ld) |=> (cnt == $past(cnt) + 2'd1));

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cke_n |=> ($stable(rd_v) && $stable(q) && $stable(s2_wr) && $stable(cnt)));

  assert_wr_float_R9: assert property (@(posedge clk) disable iff (!rst_n)
    s2_wr |-> !rd_v);
endmodule

// File: tb/test_nt_burst_sram.sv
`timescale 1ns/1ps
module test_nt_burst_sram;
  localparam int AW = 8, NL = 4, LW = 9, DW = NL * LW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, ce1_n, ce2, ce3_n, adv_ld, we_n, oe_n, cke_n, sleep;
  logic [NL-1:0] bw_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] tb_q;
  logic          tb_drv;
  wire  [DW-1:0] dq;
  assign dq = tb_drv ? tb_q : {DW{1'bz}};

  nt_burst_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) i_nt_burst_sram (
    .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .adv_ld(adv_ld), .we_n(we_n), .bw_n(bw_n), .oe_n(oe_n), .cke_n(cke_n),
    .sleep(sleep), .addr(addr), .dq(dq));

  logic [DW-1:0] ref_m [1 << AW];
  int            b_kind, b_base, b_cnt;
  int            pk [2];
  logic [DW-1:0] pd [2];
  logic [DW-1:0] in_data;
  int            errs = 0, checks = 0;
  string         req = "R10";

  function automatic logic [DW-1:0] pat(input int n);
    logic [31:0] m;
    m = 32'(n) * 32'h9E3779B1;
    return {4'(n), m};
  endfunction

  task automatic model_edge();
    int a, k;
    if (!rst_n || cke_n) return;
    if (!adv_ld) begin
      if (ce1_n || !ce2 || ce3_n) b_kind = 0;
      else b_kind = we_n ? 1 : 2;
      b_base = int'(addr);
      b_cnt  = 0;
    end else begin
      b_cnt = (b_cnt + 1) % 4;
    end
    a = (b_base & ~3) | ((b_base + b_cnt) & 3);
    k = b_kind;
    if (k == 2 && bw_n == '1) k = 0;
    pk[1] = pk[0];
    pd[1] = pd[0];
    pk[0] = k;
    if (k == 2) begin
      for (int i = 0; i < NL; i++)
        if (!bw_n[i]) ref_m[a][i*LW +: LW] = in_data[i*LW +: LW];
      pd[0] = in_data;
    end else if (k == 1) begin
      pd[0] = ref_m[a];
    end else begin
      pd[0] = '0;
    end
  endtask

  task automatic check_bus();
    logic [DW-1:0] e;
    if (pk[1] == 1)      e = (!oe_n && !sleep) ? pd[1] : {DW{1'bz}};
    else if (pk[1] == 2) e = pd[1];
    else                 e = {DW{1'bz}};
    checks++;
    if (dq !== e) begin
      errs++;
      $display("FAIL %s: dq=%h expected %h at %0t", req, dq, e, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    #1;
    tb_drv = (pk[1] == 2);
    tb_q   = pd[1];
    @(negedge clk);
    #1;
    check_bus();
  endtask

  task automatic ld(input int kind, input int a, input logic [NL-1:0] bw, input logic [DW-1:0] d);
    cke_n = 0; adv_ld = 0; ce1_n = (kind == 0); ce2 = 1; ce3_n = 0;
    we_n = (kind != 2); bw_n = bw; addr = AW'(a); in_data = d;
    step();
  endtask

  task automatic dsel(input int v);
    cke_n = 0; adv_ld = 0; ce1_n = (v == 0); ce2 = (v != 1); ce3_n = (v == 2);
    we_n = v[0]; bw_n = '0; addr = AW'(v * 5);
    step();
  endtask

  task automatic ct(input logic [NL-1:0] bw, input logic [DW-1:0] d);
    cke_n = 0; adv_ld = 1; bw_n = bw; in_data = d; addr = ~addr;
    step();
  endtask

  task automatic stall();
    cke_n = 1; adv_ld = 0; ce1_n = 0; ce2 = 1; ce3_n = 0; we_n = 0; bw_n = '0;
    step();
    cke_n = 0;
  endtask

  task automatic flush();
    dsel(0);
    dsel(0);
  endtask

  initial begin
    #100000;
    errs++;
    checks++;
    $display("FAIL R10 watchdog: run still active at %0t, expected completion", $time);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    pk[0] = 0; pk[1] = 0; pd[0] = '0; pd[1] = '0;
    b_kind = 0; b_base = 0; b_cnt = 0;
    tb_drv = 0; tb_q = '0;
    rst_n = 0; ce1_n = 1; ce2 = 0; ce3_n = 1; adv_ld = 0; we_n = 1;
    bw_n = '1; oe_n = 0; cke_n = 0; sleep = 0; addr = '0; in_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    req = "R10";
    check_bus();
    rst_n = 1;
    flush();

    req = "R3";
    ld(2, 8'h10, 4'h0, pat(1));
    req = "R5";
    ct(4'h0, pat(2)); ct(4'h0, pat(3)); ct(4'h0, pat(4));
    for (int a = 8'h30; a < 8'h34; a++) ld(2, a, 4'h0, pat(a));
    flush();

    req = "R2";
    ld(1, 8'h12, 4'h0, '0);
    req = "R5";
    ct(4'h0, '0); ct(4'h0, '0); ct(4'h0, '0);
    flush();

    req = "R11";
    ld(2, 8'h20, 4'h0, pat(20));
    ld(1, 8'h11, 4'h0, '0);
    ld(2, 8'h21, 4'h0, pat(21));
    ld(1, 8'h20, 4'h0, '0);
    ld(1, 8'h21, 4'h0, '0);
    ld(2, 8'h22, 4'h0, pat(22));
    ld(1, 8'h22, 4'h0, '0);
    flush();

    req = "R3";
    ld(2, 8'h20, 4'b1010, pat(77));
    ld(1, 8'h20, 4'h0, '0);
    ld(2, 8'h21, 4'b0111, pat(78));
    flush();
    ld(1, 8'h21, 4'h0, '0);
    flush();

    req = "R4";
    ld(2, 8'h10, 4'hF, pat(99));
    ld(1, 8'h10, 4'h0, '0);
    ld(2, 8'h30, 4'h0, pat(40));
    ct(4'hF, pat(41));
    ct(4'h0, pat(42));
    flush();
    req = "R5";
    ld(1, 8'h30, 4'h0, '0);
    ct(4'h0, '0); ct(4'h0, '0); ct(4'h0, '0);
    flush();

    req = "R9";
    ld(1, 8'h11, 4'h0, '0);
    oe_n = 1;
    ct(4'h0, '0);
    ct(4'h0, '0);
    oe_n = 0;
    ct(4'h0, '0);
    ct(4'h0, '0);
    flush();
    ld(2, 8'h50, 4'h0, pat(50));
    ld(2, 8'h51, 4'h0, pat(51));
    flush();

    req = "R7";
    ld(1, 8'h13, 4'h0, '0);
    ct(4'h0, '0);
    stall(); stall();
    ct(4'h0, '0);
    stall();
    ct(4'h0, '0);
    flush();
    ld(2, 8'h40, 4'h0, pat(60));
    ct(4'h0, pat(61));
    stall(); stall();
    ct(4'h0, pat(62));
    stall();
    ct(4'h0, pat(63));
    flush();
    ld(1, 8'h40, 4'h0, '0);
    ct(4'h0, '0); ct(4'h0, '0); ct(4'h0, '0);
    flush();

    req = "R1";
    dsel(0); dsel(1); dsel(2); dsel(0);
    req = "R6";
    ct(4'h0, pat(5)); ct(4'h0, pat(6)); ct(4'h0, pat(7));
    flush();
    ld(1, 8'h42, 4'h0, '0);
    flush();

    req = "R8";
    ld(1, 8'h50, 4'h0, '0);
    sleep = 1;
    ct(4'h0, '0);
    ct(4'h0, '0);
    sleep = 0;
    ct(4'h0, '0);
    flush();

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule